// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-visible register bank of a small multi-channel memory-to-memory DMA controller. A bus master reaches it through a plain register port. Each access carries an address, and the address names both a channel and a 32-bit word inside that channel's window. Each channel keeps a control word and a "next" descriptor that software fills in. The descriptor holds a configuration word, a byte count, a destination and a source. Each channel also keeps an "exec" copy of that descriptor, which is read-only and is loaded when a transfer starts.

Writing the control word with its run bit set first checks the next descriptor. A descriptor that passes is copied into the exec registers, and the transfer engine receives a one-cycle start pulse carrying the channel number and the descriptor. A descriptor that fails raises the channel's error status and nothing is started. The engine later reports completion or failure per channel. Those reports set the status bits in the control word. Two interrupt lines per channel follow the status bits, each through its own enable bit.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero and `irq`, `eng_start` and `bus_rdata` are low.
- R2: A read returns its data on `bus_rdata` one cycle after the request. The channel index is `bus_addr[15:12]` and the word index is `bus_addr[11:2]`. The defined word indices are:
  - 0: control
  - 1: next config
  - 2/3: next byte count (low/high)
  - 4/5: next destination (low/high)
  - 6/7: next source (low/high)
  - 0x41: exec config
  - 0x42/0x43: exec byte count
  - 0x44/0x45: exec destination
  - 0x46/0x47: exec source

  A 32-bit access (`bus_wide`=0) uses word W in bits 31:0, and a read returns zero in bits 63:32. A 64-bit access uses word W in bits 31:0 and word W+1 in bits 63:32.
- R3: Writes to exec words have no effect. Undefined word indices read zero and ignore writes. So does any address with `bus_addr[1:0]` nonzero.
- R4: An access whose channel index is at or above the channel count reads zero and ignores writes.
- R5: A control write with bit 1 (run) set starts a transfer when the stored next descriptor is valid. Bits 30 (done) and 31 (error) are then cleared, the rest of the written value is stored, and the next descriptor is copied to exec. In the following cycle `eng_start` is high for one cycle, with `eng_chan` and the descriptor outputs showing the channel and its exec values.
- R6: The start check uses the next descriptor as stored before the access. The write size is config bits 27:24 and the read size is config bits 31:28. The descriptor is rejected if any of these holds:
  - the byte count is zero;
  - the two sizes differ;
  - the byte count is not a multiple of 2^min(size,6).

  On rejection the written value is stored with bit 31 set and bit 1 cleared. There is no start pulse and exec is unchanged.
- R7: A control write with bit 1 clear stores the written value unchanged and starts nothing.
- R8: `eng_done[n]` sets bit 30 and clears bit 1 of channel n's control word, and `eng_err[n]` sets bit 31 and clears bit 1. The change is visible from the next cycle.
- R9: When a control write to channel n falls in the same cycle as an engine report for channel n, the write takes effect and that report is discarded.
- R10: `irq[2n]` equals control bit 14 AND bit 30 of channel n. `irq[2n+1]` equals control bit 15 AND bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| bus_addr | input | AW (16) | Channel index and byte offset |
| bus_wdata | input | 64 | Write data, little-endian |
| bus_rdata | output | 64 | Read data, one cycle after the request |
| eng_done | input | NCH (4) | Per-channel completion report |
| eng_err | input | NCH (4) | Per-channel failure report |
| eng_start | output | 1 | One-cycle transfer start pulse |
| eng_chan | output | log2(NCH) | Channel being started |
| eng_cfg | output | 32 | Exec config of the started channel |
| eng_bytes | output | 64 | Exec byte count |
| eng_dst | output | 64 | Exec destination |
| eng_src | output | 64 | Exec source |
| irq | output | 2*NCH | Done/error interrupt pairs |

## Verification
A control write and an engine report for the same channel can land in the same cycle. Between them they decide the state of the done, error and run bits. The bench provokes this collision directly: it writes a control value whose done bit is clear while the engine reports completion. It then reads the control word back and checks that the done bit stayed clear and the done interrupt stayed low. Randomised traffic keeps repeating the overlap across all channels. Every result is judged against a model that applies the written value and drops the report.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int CTRL_RUN     = 1;
  localparam int CTRL_DONE_IE = 14;
  localparam int CTRL_ERR_IE  = 15;
  localparam int CTRL_DONE    = 30;
  localparam int CTRL_ERR     = 31;

  localparam int CFG_WSZ_LSB = 24;
  localparam int CFG_RSZ_LSB = 28;
  localparam int SIZE_CAP    = 6;

  localparam int OFS_BITS = 12;
  localparam int WIX      = 10;

  // word indices inside one channel window
  localparam int W_CTRL  = 'h00;
  localparam int W_NCFG  = 'h01;
  localparam int W_NBYT  = 'h02;
  localparam int W_NDST  = 'h04;
  localparam int W_NSRC  = 'h06;
  localparam int W_XCFG  = 'h41;
  localparam int W_XBYT  = 'h42;
  localparam int W_XDST  = 'h44;
  localparam int W_XSRC  = 'h46;

  typedef struct packed {
    logic [31:0] cfg;
    logic [63:0] bytes;
    logic [63:0] dst;
    logic [63:0] src;
  } desc_t;
endpackage

// File: rtl/dma_start_check.sv
module dma_start_check
  import dma_regs_pkg::*;
(
  input  logic [31:0] cfg,
  input  logic [63:0] bytes,
  output logic        ok
);
  logic [3:0]  wsz;
  logic [3:0]  rsz;
  logic [2:0]  lg;
  logic [63:0] mask;

  always_comb begin
    wsz  = cfg[CFG_WSZ_LSB +: 4];
    rsz  = cfg[CFG_RSZ_LSB +: 4];
    lg   = (wsz > 4'(SIZE_CAP)) ? 3'(SIZE_CAP) : wsz[2:0];
    mask = (64'd1 << lg) - 64'd1;
    ok   = (bytes != 64'd0) && (wsz == rsz) && ((bytes & mask) == 64'd0);
  end
endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
  import dma_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_sel,
  input  logic [WIX-1:0] idx,
  input  logic        wide,
  input  logic [63:0] wdata,
  input  logic        eng_done,
  input  logic        eng_err,
  output logic [31:0] ctrl_o,
  output desc_t       exec_o,
  output logic [63:0] rdata_o,
  output logic        fire_o
);
  localparam int NWR = 8;

  logic [31:0] ctrl_q, ctrl_d;
  logic [31:0] ncfg_q, ncfg_d;
  logic [63:0] nbyt_q, nbyt_d, ndst_q, ndst_d, nsrc_q, nsrc_d;
  desc_t       exec_q, exec_d;
  logic        ctrl_en, next_en, fire, ok;
  logic [WIX:0] idx0, idx1;
  logic [NWR-1:0] whit;
  logic [31:0] wdat [NWR];

  dma_start_check u_chk (.cfg(ncfg_q), .bytes(nbyt_q), .ok(ok));

  always_comb begin
    idx0 = {1'b0, idx};
    idx1 = idx0 + 1'b1;
    for (int k = 0; k < NWR; k++) begin
      whit[k] = wr_sel && ((idx0 == (WIX+1)'(k)) || (wide && (idx1 == (WIX+1)'(k))));
      wdat[k] = (idx0 == (WIX+1)'(k)) ? wdata[31:0] : wdata[63:32];
    end
  end

  // next-state: descriptor shadow
  always_comb begin
    ncfg_d = whit[W_NCFG] ? wdat[W_NCFG] : ncfg_q;
    nbyt_d = {whit[W_NBYT+1] ? wdat[W_NBYT+1] : nbyt_q[63:32],
              whit[W_NBYT]   ? wdat[W_NBYT]   : nbyt_q[31:0]};
    ndst_d = {whit[W_NDST+1] ? wdat[W_NDST+1] : ndst_q[63:32],
              whit[W_NDST]   ? wdat[W_NDST]   : ndst_q[31:0]};
    nsrc_d = {whit[W_NSRC+1] ? wdat[W_NSRC+1] : nsrc_q[63:32],
              whit[W_NSRC]   ? wdat[W_NSRC]   : nsrc_q[31:0]};
    next_en = |whit[NWR-1:1];
  end

  // next-state: control word and exec copy
  always_comb begin
    ctrl_d = ctrl_q;
    exec_d = exec_q;
    fire   = 1'b0;
    if (whit[W_CTRL]) begin
      ctrl_d = wdat[W_CTRL];
      if (wdat[W_CTRL][CTRL_RUN]) begin
        if (ok) begin
          ctrl_d[CTRL_DONE] = 1'b0;
          ctrl_d[CTRL_ERR]  = 1'b0;
          fire   = 1'b1;
          exec_d = '{cfg: ncfg_q, bytes: nbyt_q, dst: ndst_q, src: nsrc_q};
        end else begin
          ctrl_d[CTRL_ERR] = 1'b1;
          ctrl_d[CTRL_RUN] = 1'b0;
        end
      end
    end else begin
      if (eng_done) begin
        ctrl_d[CTRL_DONE] = 1'b1;
        ctrl_d[CTRL_RUN]  = 1'b0;
      end
      if (eng_err) begin
        ctrl_d[CTRL_ERR] = 1'b1;
        ctrl_d[CTRL_RUN] = 1'b0;
      end
    end
    ctrl_en = whit[W_CTRL] | eng_done | eng_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ncfg_q <= '0;
      nbyt_q <= '0;
      ndst_q <= '0;
      nsrc_q <= '0;
      exec_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (next_en) begin
        ncfg_q <= ncfg_d;
        nbyt_q <= nbyt_d;
        ndst_q <= ndst_d;
        nsrc_q <= nsrc_d;
      end
      if (fire) exec_q <= exec_d;
    end
  end

  function automatic logic [31:0] rd_word(input logic [WIX:0] w);
    case (w)
      (WIX+1)'(W_CTRL):   rd_word = ctrl_q;
      (WIX+1)'(W_NCFG):   rd_word = ncfg_q;
      (WIX+1)'(W_NBYT):   rd_word = nbyt_q[31:0];
      (WIX+1)'(W_NBYT+1): rd_word = nbyt_q[63:32];
      (WIX+1)'(W_NDST):   rd_word = ndst_q[31:0];
      (WIX+1)'(W_NDST+1): rd_word = ndst_q[63:32];
      (WIX+1)'(W_NSRC):   rd_word = nsrc_q[31:0];
      (WIX+1)'(W_NSRC+1): rd_word = nsrc_q[63:32];
      (WIX+1)'(W_XCFG):   rd_word = exec_q.cfg;
      (WIX+1)'(W_XBYT):   rd_word = exec_q.bytes[31:0];
      (WIX+1)'(W_XBYT+1): rd_word = exec_q.bytes[63:32];
      (WIX+1)'(W_XDST):   rd_word = exec_q.dst[31:0];
      (WIX+1)'(W_XDST+1): rd_word = exec_q.dst[63:32];
      (WIX+1)'(W_XSRC):   rd_word = exec_q.src[31:0];
      (WIX+1)'(W_XSRC+1): rd_word = exec_q.src[63:32];
      default:            rd_word = 32'h0;
    endcase
  endfunction

  always_comb begin
    rdata_o = {wide ? rd_word(idx1) : 32'h0, rd_word(idx0)};
  end

  assign ctrl_o = ctrl_q;
  assign exec_o = exec_q;
  assign fire_o = fire;

  AST_START_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ctrl_q[CTRL_RUN] && !ctrl_q[CTRL_DONE] && !ctrl_q[CTRL_ERR] && exec_q.bytes != 64'd0)); // R5
  AST_REJECT_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (whit[W_CTRL] && wdat[W_CTRL][CTRL_RUN] && !ok) |=> (ctrl_q[CTRL_ERR] && !ctrl_q[CTRL_RUN])); // R6
  AST_DONE_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!whit[W_CTRL] && eng_done) |=> (ctrl_q[CTRL_DONE] && !ctrl_q[CTRL_RUN])); // R8
  AST_WRITE_BEATS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (whit[W_CTRL] && eng_done && !wdat[W_CTRL][CTRL_DONE] && !wdat[W_CTRL][CTRL_RUN]) |=> !ctrl_q[CTRL_DONE]); // R9
  AST_EXEC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !whit[W_CTRL] |=> $stable(exec_q)); // R3
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic                   bus_wide,
  input  logic [AW-1:0]          bus_addr,
  input  logic [63:0]            bus_wdata,
  output logic [63:0]            bus_rdata,
  input  logic [NCH-1:0]         eng_done,
  input  logic [NCH-1:0]         eng_err,
  output logic                   eng_start,
  output logic [$clog2(NCH)-1:0] eng_chan,
  output logic [31:0]            eng_cfg,
  output logic [63:0]            eng_bytes,
  output logic [63:0]            eng_dst,
  output logic [63:0]            eng_src,
  output logic [2*NCH-1:0]       irq
);
  localparam int CIW  = AW - OFS_BITS;
  localparam int SELW = $clog2(NCH);

  logic [1:0]     rst_sync;
  logic           rst_i_n;
  logic [CIW-1:0] chan;
  logic [WIX-1:0] idx;
  logic           chan_ok;
  logic [NCH-1:0] fire;
  logic [31:0]    ctrl [NCH];
  desc_t          exec [NCH];
  logic [63:0]    rd_arr [NCH];
  logic [63:0]    rdata_d, rdata_q;
  logic           rd_en;
  logic           start_d, start_q;
  logic [SELW-1:0] sel_d, sel_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  always_comb begin
    chan    = bus_addr[AW-1:OFS_BITS];
    idx     = bus_addr[OFS_BITS-1:2];
    chan_ok = (32'(chan) < NCH) && (bus_addr[1:0] == 2'b00);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan_slice u_slice (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr_sel  (bus_req && bus_we && chan_ok && (32'(chan) == g)),
      .idx     (idx),
      .wide    (bus_wide),
      .wdata   (bus_wdata),
      .eng_done(eng_done[g]),
      .eng_err (eng_err[g]),
      .ctrl_o  (ctrl[g]),
      .exec_o  (exec[g]),
      .rdata_o (rd_arr[g]),
      .fire_o  (fire[g])
    );
    assign irq[2*g]   = ctrl[g][CTRL_DONE_IE] & ctrl[g][CTRL_DONE];
    assign irq[2*g+1] = ctrl[g][CTRL_ERR_IE]  & ctrl[g][CTRL_ERR];
  end

  always_comb begin
    rd_en   = bus_req && !bus_we;
    rdata_d = chan_ok ? rd_arr[chan[SELW-1:0]] : 64'h0;
    start_d = |fire;
    sel_d   = '0;
    for (int c = 0; c < NCH; c++) begin
      if (fire[c]) sel_d = SELW'(c);
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdata_q <= '0;
      start_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      if (rd_en) rdata_q <= rdata_d;
      start_q <= start_d;
      if (start_d) sel_q <= sel_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign eng_start = start_q;
  assign eng_chan  = sel_q;
  assign eng_cfg   = exec[sel_q].cfg;
  assign eng_bytes = exec[sel_q].bytes;
  assign eng_dst   = exec[sel_q].dst;
  assign eng_src   = exec[sel_q].src;

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_req && !bus_we && 32'(chan) >= NCH) |=> (bus_rdata == 64'h0)); // R4
  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(fire)); // R5
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we, bus_wide;
  logic [15:0] bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic [3:0]  eng_done, eng_err;
  logic        eng_start;
  logic [1:0]  eng_chan;
  logic [31:0] eng_cfg;
  logic [63:0] eng_bytes, eng_dst, eng_src;
  logic [7:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  dma_chan_regs #(.NCH(NCH), .AW(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_done(eng_done), .eng_err(eng_err), .eng_start(eng_start), .eng_chan(eng_chan),
    .eng_cfg(eng_cfg), .eng_bytes(eng_bytes), .eng_dst(eng_dst), .eng_src(eng_src), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [31:0] m_ctrl [NCH];
  logic [31:0] m_ncfg [NCH];
  logic [63:0] m_nb [NCH], m_nd [NCH], m_ns [NCH];
  logic [31:0] m_xc [NCH];
  logic [63:0] m_xb [NCH], m_xd [NCH], m_xs [NCH];

  function automatic logic [31:0] mword(int c, int w);
    case (w)
      0: return m_ctrl[c];
      1: return m_ncfg[c];
      2: return m_nb[c][31:0];
      3: return m_nb[c][63:32];
      4: return m_nd[c][31:0];
      5: return m_nd[c][63:32];
      6: return m_ns[c][31:0];
      7: return m_ns[c][63:32];
      'h41: return m_xc[c];
      'h42: return m_xb[c][31:0];
      'h43: return m_xb[c][63:32];
      'h44: return m_xd[c][31:0];
      'h45: return m_xd[c][63:32];
      'h46: return m_xs[c][31:0];
      'h47: return m_xs[c][63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic mput(int c, int w, logic [31:0] d);
    case (w)
      1: m_ncfg[c] = d;
      2: m_nb[c][31:0] = d;
      3: m_nb[c][63:32] = d;
      4: m_nd[c][31:0] = d;
      5: m_nd[c][63:32] = d;
      6: m_ns[c][31:0] = d;
      7: m_ns[c][63:32] = d;
      default: ;
    endcase
  endtask

  function automatic bit mok(int c);
    int ws = int'(m_ncfg[c][27:24]);
    int rs = int'(m_ncfg[c][31:28]);
    int lg = (ws > 6) ? 6 : ws;
    return (m_nb[c] != 0) && (ws == rs) && ((m_nb[c] % (64'd1 << lg)) == 0);
  endfunction

  function automatic logic [7:0] mirq();
    logic [7:0] v;
    for (int c = 0; c < NCH; c++) begin
      v[2*c]   = m_ctrl[c][14] & m_ctrl[c][30];
      v[2*c+1] = m_ctrl[c][15] & m_ctrl[c][31];
    end
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit req, bit we, bit wide, logic [15:0] addr,
                      logic [63:0] wd, logic [3:0] dn, logic [3:0] er);
    int ch, w;
    bit valid, is_rd, ctrl_hit, exp_st;
    int exp_ch;
    logic [63:0] exp_rd;
    logic [31:0] v;
    @(negedge clk);
    bus_req = req; bus_we = we; bus_wide = wide; bus_addr = addr;
    bus_wdata = wd; eng_done = dn; eng_err = er;
    ch = int'(addr[15:12]);
    w  = int'(addr[11:2]);
    valid = (ch < NCH) && (addr[1:0] == 2'b00);
    is_rd = req && !we;
    exp_rd = 64'h0;
    if (is_rd && valid)
      exp_rd = {wide ? mword(ch, w + 1) : 32'h0, mword(ch, w)};
    ctrl_hit = req && we && valid && (w == 0);
    exp_st = 0; exp_ch = 0;
    if (ctrl_hit) begin
      v = wd[31:0];
      if (v[1]) begin
        if (mok(ch)) begin
          v[30] = 1'b0; v[31] = 1'b0;
          m_xc[ch] = m_ncfg[ch]; m_xb[ch] = m_nb[ch];
          m_xd[ch] = m_nd[ch];   m_xs[ch] = m_ns[ch];
          exp_st = 1; exp_ch = ch;
        end else begin
          v[31] = 1'b1; v[1] = 1'b0;
        end
      end
    end
    if (req && we && valid) begin
      mput(ch, w, wd[31:0]);
      if (wide) mput(ch, w + 1, wd[63:32]);
    end
    if (ctrl_hit) m_ctrl[ch] = v;
    for (int c = 0; c < NCH; c++) begin
      if (!(ctrl_hit && ch == c)) begin
        if (dn[c]) begin m_ctrl[c][30] = 1'b1; m_ctrl[c][1] = 1'b0; end
        if (er[c]) begin m_ctrl[c][31] = 1'b1; m_ctrl[c][1] = 1'b0; end
      end
    end
    @(posedge clk);
    #1;
    if (is_rd) check({tag, " read data"}, bus_rdata, exp_rd);
    check("R5 start pulse", {63'h0, eng_start}, {63'h0, exp_st});
    if (exp_st) begin
      check("R5 start channel", {62'h0, eng_chan}, 64'(exp_ch));
      check("R5 start cfg", {32'h0, eng_cfg}, {32'h0, m_xc[exp_ch]});
      check("R5 start bytes", eng_bytes, m_xb[exp_ch]);
      check("R5 start dst", eng_dst, m_xd[exp_ch]);
      check("R5 start src", eng_src, m_xs[exp_ch]);
    end
    check("R10 irq", {56'h0, irq}, {56'h0, mirq()});
    bus_req = 0; bus_we = 0;
  endtask

  function automatic logic [15:0] adr(int c, int w);
    return 16'((c << 12) | (w << 2));
  endfunction

  task automatic wr32(string t, int c, int w, logic [31:0] d);
    step(t, 1, 1, 0, adr(c, w), {32'h0, d}, 4'h0, 4'h0);
  endtask
  task automatic wr64(string t, int c, int w, logic [63:0] d);
    step(t, 1, 1, 1, adr(c, w), d, 4'h0, 4'h0);
  endtask
  task automatic rd(string t, int c, int w, bit wide);
    step(t, 1, 0, wide, adr(c, w), 64'h0, 4'h0, 4'h0);
  endtask
  task automatic desc(int c, logic [31:0] cfg, logic [63:0] b, logic [63:0] d, logic [63:0] s);
    wr32("R2", c, 1, cfg);
    wr64("R2", c, 2, b);
    wr64("R2", c, 4, d);
    wr64("R2", c, 6, s);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int sd;
    sd = $urandom(32'd20240611);
    for (int c = 0; c < NCH; c++) begin
      m_ctrl[c] = 0; m_ncfg[c] = 0; m_nb[c] = 0; m_nd[c] = 0; m_ns[c] = 0;
      m_xc[c] = 0; m_xb[c] = 0; m_xd[c] = 0; m_xs[c] = 0;
    end
    bus_req = 0; bus_we = 0; bus_wide = 0; bus_addr = 0; bus_wdata = 0;
    eng_done = 0; eng_err = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 rdata", bus_rdata, 64'h0);
    check("R1 irq", {56'h0, irq}, 64'h0);
    check("R1 start", {63'h0, eng_start}, 64'h0);
    rd("R1", 0, 0, 1);
    rd("R1", 3, 'h46, 1);

    // R2 read-back
    desc(1, 32'h3300_0000, 64'd64, 64'h0000_0001_8000_0000, 64'h0000_0002_4000_0000);
    rd("R2", 1, 3, 0);
    rd("R2", 1, 4, 1);
    rd("R2", 1, 1, 0);

    // R5 start with both interrupt enables
    wr32("R5", 1, 0, 32'h0000_C002);
    rd("R5", 1, 'h42, 1);
    rd("R5", 1, 0, 0);

    // R3 exec is read-only, undefined words
    wr64("R3", 1, 'h42, 64'hDEAD_BEEF_0BAD_F00D);
    rd("R3", 1, 'h42, 1);
    wr32("R3", 1, 'h40, 32'hFFFF_FFFF);
    rd("R3", 1, 'h40, 0);
    step("R3", 1, 1, 0, adr(1, 1) | 16'h1, 64'h1234, 4'h0, 4'h0);
    rd("R3", 1, 1, 0);

    // R8 engine completion on channel 1
    step("R8", 0, 0, 0, 0, 0, 4'b0010, 4'h0);
    rd("R8", 1, 0, 0);

    // R4 out-of-range channel
    wr32("R4", 5, 1, 32'h5555_5555);
    rd("R4", 5, 1, 0);
    rd("R4", 15, 0, 1);

    // R6 rejection cases on channel 2
    desc(2, 32'h3300_0000, 64'd0, 64'h10, 64'h20);
    wr32("R6 zero", 2, 0, 32'h0000_8002);
    rd("R6 zero", 2, 0, 0);
    desc(2, 32'h3300_0000, 64'd12, 64'h10, 64'h20);
    wr32("R6 multiple", 2, 0, 32'h0000_8002);
    desc(2, 32'h3200_0000, 64'd64, 64'h10, 64'h20);
    wr32("R6 mismatch", 2, 0, 32'h0000_8002);
    desc(2, 32'h9900_0000, 64'd32, 64'h10, 64'h20);
    wr32("R6 cap", 2, 0, 32'h0000_8002);
    rd("R6 cap", 2, 'h42, 1);
    desc(2, 32'h9900_0000, 64'd128, 64'h10, 64'h20);
    wr32("R6 cap ok", 2, 0, 32'h0000_8002);
    rd("R6 cap ok", 2, 0, 0);

    // R7 direct status write, no start
    wr32("R7", 3, 0, 32'h4000_4000);
    rd("R7", 3, 0, 0);

    // R9 control write collides with engine report
    step("R9", 1, 1, 0, adr(1, 0), 64'h0000_4000, 4'b0010, 4'b0010);
    rd("R9", 1, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 4'b0010, 4'h0);

    // randomised traffic
    for (int i = 0; i < 3000; i++) begin
      int c, wsel, w;
      bit we, wide;
      logic [15:0] a;
      logic [63:0] d;
      logic [3:0] dn, er;
      c = int'($urandom % 6);
      wsel = int'($urandom % 18);
      w = (wsel < 8) ? wsel : (wsel < 16) ? ('h40 + wsel - 8) : (wsel == 16 ? 'h20 : 0);
      we = $urandom % 2;
      wide = $urandom % 2;
      a = adr(c, w);
      if ($urandom % 20 == 0) a[1:0] = 2'($urandom % 4);
      d = {$urandom, $urandom};
      if (w == 1) begin
        d[27:24] = 4'($urandom % 9);
        d[31:28] = ($urandom % 4 == 0) ? 4'($urandom) : d[27:24];
      end
      if (w == 2) d[31:0] = $urandom % 256;
      if (w == 2 || w == 3) d[63:32] = 0;
      if (w == 0) d[1] = ($urandom % 3 != 0);
      dn = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      er = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
      step(we ? "R2 rand write" : "R2 rand read", 1, we, wide, a, d, dn, er);
    end
    for (int c = 0; c < NCH; c++) begin
      rd("R2 final", c, 0, 1);
      rd("R2 final", c, 'h46, 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule